// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Trigger Controller

This block decides the clock cycle in which the primary switch of a quasi-resonant flyback converter should be turned on. Two digitised comparator flags come from the winding sense pin: one says the pin is above the arming level, the other says it is below the trigger level. A valid turn-on needs a rising crossing of the arming level first. A falling crossing of the trigger level then requests turn-on.

After every turn-off, a blanking window hides falling crossings. Its length comes from the compensation voltage, which arrives as an unsigned millivolt code. When the load is light, the compensation voltage is low, so the window is long and whole ringing valleys are skipped. A minimum spacing between requests caps the switching frequency. When no valid trigger arrives, a fallback starter forces turn-on at one of two rates, chosen by the compensation voltage.

The block also masks the current-sense turn-off request for a short interval after the gate rises. The peak-current turn-off stage downstream consumes the one-cycle `gate_on_o` request and the masked `cs_off_o`.

Top module: `qr_turnon_ctrl`

## Requirements
- R1: A turn-on request from the trigger path needs an arm event: a 0-to-1 change of `zcd_arm_i`, sampled while `gate_i` is low, after the most recent request. If `zcd_arm_i` rises while `gate_i` is high, the block does not become armed.
- R2: A trigger event is a 0-to-1 change of `zcd_trig_i`. When the block is armed, `gate_i` is low, and both the blanking and the spacing rules are met, `gate_on_o` is high for exactly the one cycle that follows the clock edge that samples the event.
- R3: The block latches the blanking length T, in cycles, from `comp_mv_i` at the clock edge that first samples `gate_i` low. T is BLANK_MAX_CYC when `comp_mv_i` <= VC_LO_MV, and BLANK_MIN_CYC when `comp_mv_i` >= VC_HI_MV. Between the two, T = BLANK_MAX_CYC - floor((BLANK_MAX_CYC-BLANK_MIN_CYC)*(comp_mv_i-VC_LO_MV)/(VC_HI_MV-VC_LO_MV)).
- R4: A trigger event is honoured only if the edge that samples it comes at least T+1 edges after the edge that first sampled `gate_i` low. Earlier events are dropped. A later event in the same off period, with the arm still held, is accepted, so valleys are skipped.
- R5: Two rising edges of `gate_on_o` are never closer than MIN_PER_CYC cycles. A trigger that comes sooner is dropped.
- R6: When no trigger occurs and `gate_i` is low, the starter raises `gate_on_o` every START_SLOW_CYC cycles if `comp_mv_i` <= BURST_MV, and every START_FAST_CYC cycles if `comp_mv_i` > BURST_MV. The period is counted from the last request, or from the release of `disable_i`.
- R7: Every request clears the arm. A further trigger needs a new arm event.
- R8: While `disable_i` is high, `gate_on_o` stays low in the next cycle. The arm is cleared, and the starter count restarts when `disable_i` is released.
- R9: `cs_off_o` follows `cs_off_i` only while `gate_i` is high. It is held low from the rise of `gate_i` until the LEB_CYC-th clock edge that samples `gate_i` high.
- R10: `gate_on_o` rises only after a clock edge that sampled `gate_i` low. A trigger event while the gate is high gives no request.
- R11: After reset, `gate_on_o` and `cs_off_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_i | input | 1 | Undervoltage or protection hold-off |
| zcd_arm_i | input | 1 | Sense pin above the arming level |
| zcd_trig_i | input | 1 | Sense pin below the trigger level |
| comp_mv_i | input | MV_W | Compensation voltage in millivolts |
| gate_i | input | 1 | Present gate state from the driver |
| cs_off_i | input | 1 | Raw current-sense turn-off request |
| gate_on_o | output | 1 | One-cycle turn-on request |
| cs_off_o | output | 1 | Turn-off request after leading-edge masking |

## Verification
The state behind these outputs is held internally: the arm flag, the latched blanking length, the off-time counter, the since-request counter and the leading-edge counter. A fault in any of them shows up at the ports as a request that lands one cycle early or late, or that appears or vanishes. A fault in the arm flag or the blanking length shows at the first trigger after the next turn-off. A fault in the since-request counter shows as a shifted starter pulse, at most one starter period later. A wrong leading-edge count changes `cs_off_o` within a few cycles of the gate rising.

// File: rtl/qr_turnon_ctrl.sv
module qr_turnon_ctrl #(
  parameter int MV_W           = 12,
  parameter int VC_LO_MV       = 900,
  parameter int VC_HI_MV       = 1300,
  parameter int BURST_MV       = 1000,
  parameter int BLANK_MAX_CYC  = 1500,
  parameter int BLANK_MIN_CYC  = 300,
  parameter int START_SLOW_CYC = 25000,
  parameter int START_FAST_CYC = 6250,
  parameter int MIN_PER_CYC    = 302,
  parameter int LEB_CYC        = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disable_i,
  input  logic            zcd_arm_i,
  input  logic            zcd_trig_i,
  input  logic [MV_W-1:0] comp_mv_i,
  input  logic            gate_i,
  input  logic            cs_off_i,
  output logic            gate_on_o,
  output logic            cs_off_o
);
  localparam int TOP1 = (START_SLOW_CYC > BLANK_MAX_CYC) ? START_SLOW_CYC : BLANK_MAX_CYC;
  localparam int TOP2 = (START_FAST_CYC > MIN_PER_CYC) ? START_FAST_CYC : MIN_PER_CYC;
  localparam int TOP3 = (TOP1 > TOP2) ? TOP1 : TOP2;
  localparam int TOP  = (TOP3 > LEB_CYC) ? TOP3 : LEB_CYC;
  localparam int CW   = $clog2(TOP + 2);
  localparam int SPAN_CYC = BLANK_MAX_CYC - BLANK_MIN_CYC;
  localparam int SPAN_MV  = VC_HI_MV - VC_LO_MV;
  localparam logic [CW-1:0] PER_M1  = CW'(MIN_PER_CYC - 1);
  localparam logic [CW-1:0] SLOW_M1 = CW'(START_SLOW_CYC - 1);
  localparam logic [CW-1:0] FAST_M1 = CW'(START_FAST_CYC - 1);
  localparam logic [CW-1:0] LEB_M1  = CW'(LEB_CYC - 1);

  logic          arm_q, trig_q, gate_q, armed;
  logic [CW-1:0] off_cnt, blank_len, since_on, leb_cnt;
  logic [31:0]   comp_ext, blank_full;
  logic [CW-1:0] blank_cyc, start_lim;
  logic          gate_rise, gate_fall, arm_edge, trig_edge;
  logic          blank_ok, cap_ok, fire_trig, fire_start, fire;

  assign comp_ext = 32'(comp_mv_i);

  always_comb begin
    if (comp_ext <= 32'(VC_LO_MV))
      blank_full = 32'(BLANK_MAX_CYC);
    else if (comp_ext >= 32'(VC_HI_MV))
      blank_full = 32'(BLANK_MIN_CYC);
    else
      blank_full = 32'(BLANK_MAX_CYC) -
                   (32'(SPAN_CYC) * (comp_ext - 32'(VC_LO_MV))) / 32'(SPAN_MV);
  end
  assign blank_cyc = blank_full[CW-1:0];

  assign gate_rise = gate_i & ~gate_q;
  assign gate_fall = ~gate_i & gate_q;
  assign arm_edge  = zcd_arm_i & ~arm_q;
  assign trig_edge = zcd_trig_i & ~trig_q;

  assign blank_ok   = off_cnt >= blank_len;
  assign cap_ok     = since_on >= PER_M1;
  assign start_lim  = (comp_ext > 32'(BURST_MV)) ? FAST_M1 : SLOW_M1;
  assign fire_trig  = armed & trig_edge & blank_ok & cap_ok;
  assign fire_start = since_on >= start_lim;
  assign fire       = ~disable_i & ~gate_i & (fire_trig | fire_start);

  assign cs_off_o = cs_off_i & gate_i & gate_q & (leb_cnt >= LEB_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= 1'b0;
      trig_q    <= 1'b0;
      gate_q    <= 1'b0;
      armed     <= 1'b0;
      off_cnt   <= '0;
      blank_len <= '0;
      since_on  <= '0;
      leb_cnt   <= '0;
      gate_on_o <= 1'b0;
    end else begin
      arm_q     <= zcd_arm_i;
      trig_q    <= zcd_trig_i;
      gate_q    <= gate_i;
      gate_on_o <= fire;

      if (disable_i || fire)
        armed <= 1'b0;
      else if (arm_edge && !gate_i)
        armed <= 1'b1;

      if (gate_fall) begin
        off_cnt   <= '0;
        blank_len <= blank_cyc;
      end else if (!gate_i && off_cnt != '1) begin
        off_cnt <= off_cnt + 1'b1;
      end

      if (disable_i || fire)
        since_on <= '0;
      else if (since_on != '1)
        since_on <= since_on + 1'b1;

      if (gate_rise)
        leb_cnt <= '0;
      else if (gate_i && leb_cnt != '1)
        leb_cnt <= leb_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qr_turnon_ctrl_chk.sv
module qr_turnon_ctrl_chk #(
  parameter int MIN_PER_CYC = 302
) (
  input logic clk,
  input logic rst_n,
  input logic disable_i,
  input logic gate_i,
  input logic gate_on_o,
  input logic cs_off_o
);
  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap <= 32'hFFFF_FFFF;
    else if (gate_on_o)
      gap <= 32'd1;
    else if (gap != 32'hFFFF_FFFF)
      gap <= gap + 32'd1;
  end

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !gate_on_o); // R8
  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on_o |-> gap >= 32'(MIN_PER_CYC)); // R5
  AST_REQ_AFTER_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on_o |-> !$past(gate_i)); // R10
  AST_LEB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_i) |-> !cs_off_o); // R9
endmodule

bind qr_turnon_ctrl qr_turnon_ctrl_chk #(.MIN_PER_CYC(MIN_PER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .disable_i(disable_i), .gate_i(gate_i),
  .gate_on_o(gate_on_o), .cs_off_o(cs_off_o)
);

// File: tb/qr_turnon_ctrl_test.sv
module qr_turnon_ctrl_test;
  localparam int BMAX = 60, BMIN = 12, LO = 900, HI = 1300, BURST = 1000;
  localparam int SSLOW = 600, SFAST = 300, MINP = 20, LEB = 4;

  logic clk = 1'b0, rst_n = 1'b0, dis = 1'b0, arm = 1'b0, trig = 1'b0;
  logic gate = 1'b0, cs_in = 1'b0;
  logic [11:0] comp = 12'd950;
  logic gon, cs_out;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  qr_turnon_ctrl #(
    .MV_W(12), .VC_LO_MV(LO), .VC_HI_MV(HI), .BURST_MV(BURST),
    .BLANK_MAX_CYC(BMAX), .BLANK_MIN_CYC(BMIN), .START_SLOW_CYC(SSLOW),
    .START_FAST_CYC(SFAST), .MIN_PER_CYC(MINP), .LEB_CYC(LEB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .disable_i(dis), .zcd_arm_i(arm),
    .zcd_trig_i(trig), .comp_mv_i(comp), .gate_i(gate), .cs_off_i(cs_in),
    .gate_on_o(gon), .cs_off_o(cs_out)
  );

  function automatic int exp_blank(int c);
    if (c <= LO) return BMAX;
    if (c >= HI) return BMIN;
    return BMAX - ((BMAX - BMIN) * (c - LO)) / (HI - LO);
  endfunction

  task automatic chk(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    dis = 1'b1; arm = 1'b0; trig = 1'b0; gate = 1'b0; cs_in = 1'b0;
    repeat (2) @(negedge clk);
    dis = 1'b0;
  endtask

  task automatic trial(input int c, input int n, input bit do_arm, output bit got);
    @(negedge clk);
    gate = 1'b1; arm = 1'b0; trig = 1'b0; comp = 12'(c);
    repeat (10) @(negedge clk);
    gate = 1'b0; arm = do_arm;
    repeat (n) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    got = gon;
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 gate_on_o after reset", int'(gon), 0);
    chk("R11 cs_off_o after reset", int'(cs_out), 0);

    // R3 R4 R2: blanking sweep over the compensation code
    quiet();
    for (int c = 800; c <= 1400; c += 25) begin
      int l;
      l = exp_blank(c);
      trial(c, l, 1'b1, got);
      chk($sformatf("R4 edge inside blank comp=%0d", c), int'(got), 0);
      trial(c, l + 1, 1'b1, got);
      chk($sformatf("R3 edge after blank comp=%0d", c), int'(got), 1);
      @(negedge clk);
      chk("R2 one-cycle request", int'(gon), 0);
    end

    // R4: valley skip within one off period
    quiet();
    @(negedge clk);
    comp = 12'd900; gate = 1'b1;
    repeat (10) @(negedge clk);
    gate = 1'b0; arm = 1'b1;
    repeat (30) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk("R4 early valley skipped", int'(gon), 0);
    trig = 1'b0;
    repeat (30) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk("R4 later valley accepted", int'(gon), 1);
    trig = 1'b0;

    // R5: request spacing sweep
    for (int g = 15; g <= 24; g++) begin
      quiet();
      trial(1400, 70, 1'b1, got);
      chk("R2 priming request", int'(got), 1);
      gate = 1'b1; arm = 1'b0;
      @(negedge clk);
      gate = 1'b0; arm = 1'b1;
      repeat (g - 2) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      chk($sformatf("R5 spacing gap=%0d", g), int'(gon), (g >= MINP) ? 1 : 0);
      trig = 1'b0;
    end

    // R7 and R1
    quiet();
    trial(950, 70, 1'b1, got);
    chk("R7 first request", int'(got), 1);
    trial(950, 70, 1'b0, got);
    chk("R7 no rearm no request", int'(got), 0);
    quiet();
    @(negedge clk);
    gate = 1'b1; arm = 1'b1;
    repeat (10) @(negedge clk);
    gate = 1'b0;
    repeat (70) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk("R1 arm during gate high ignored", int'(gon), 0);
    trig = 1'b0;

    // R10: trigger while gate high
    quiet();
    @(negedge clk);
    gate = 1'b1;
    repeat (10) @(negedge clk);
    gate = 1'b0; arm = 1'b1;
    repeat (70) @(negedge clk);
    gate = 1'b1; trig = 1'b1;
    @(negedge clk);
    chk("R10 trigger with gate high", int'(gon), 0);
    trig = 1'b0;
    @(negedge clk);
    gate = 1'b0;

    // R8: disable blocks and disarms
    quiet();
    @(negedge clk);
    gate = 1'b1;
    repeat (10) @(negedge clk);
    gate = 1'b0; arm = 1'b1;
    repeat (70) @(negedge clk);
    dis = 1'b1; trig = 1'b1;
    @(negedge clk);
    chk("R8 trigger while disabled", int'(gon), 0);
    trig = 1'b0; dis = 1'b0;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk("R8 arm cleared by disable", int'(gon), 0);
    trig = 1'b0;

    // R9: leading-edge mask
    quiet();
    @(negedge clk);
    cs_in = 1'b1;
    #1;
    chk("R9 gate low masks", int'(cs_out), 0);
    @(negedge clk);
    gate = 1'b1;
    #1;
    chk("R9 masked at gate rise", int'(cs_out), 0);
    repeat (LEB - 1) @(negedge clk);
    chk("R9 masked before LEB end", int'(cs_out), 0);
    @(negedge clk);
    chk("R9 passes after LEB", int'(cs_out), 1);
    gate = 1'b0; cs_in = 1'b0;

    // R6: starter periods
    for (int k = 0; k < 3; k++) begin
      int c, s;
      c = (k == 0) ? 950 : (k == 1) ? 1000 : 1001;
      s = (c > BURST) ? SFAST : SSLOW;
      @(negedge clk);
      comp = 12'(c);
      quiet();
      repeat (s - 1) @(negedge clk);
      chk($sformatf("R6 before period comp=%0d", c), int'(gon), 0);
      @(negedge clk);
      chk($sformatf("R6 first starter comp=%0d", c), int'(gon), 1);
      repeat (s - 1) @(negedge clk);
      chk($sformatf("R6 between starters comp=%0d", c), int'(gon), 0);
      @(negedge clk);
      chk($sformatf("R6 second starter comp=%0d", c), int'(gon), 1);
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule